// File: doc/BRIEF.md
# File-Register ALU Execute Stage

This block is the single-cycle execute stage of a small 8-bit accumulator machine. Each cycle it takes an operation that has already been decoded, a 7-bit file-register address, a destination bit and an 8-bit immediate. It combines the addressed file-register operand, or the immediate, with the working register. The operations are increment, decrement, inclusive OR with a file register and inclusive OR with the immediate.

The result goes either to the working register, which is held inside the block, or back to the addressed file register. The 128-entry file-register array sits outside the block. The block reads it through an asynchronous read-data input and writes it through a write port it drives in the same cycle.

The block also holds the zero flag. Plain increment and both OR operations update that flag. The two skip-type operations leave it untouched and instead raise a zero-result strobe for the sequencer's skip logic.

Top module: `fileAluCore`

## Requirements
- R1: While reset (rstN low) is held and right after it is released, the working-register value is 0x00, the zero flag is 0, and no write enable is asserted while no valid operation is presented.
- R2: Increment (opCode 1) and increment-with-skip (opCode 3) produce the file operand plus one, and decrement-with-skip (opCode 2) produces the operand minus one. The arithmetic wraps modulo 256, so 0xFF+1 gives 0x00 and 0x00-1 gives 0xFF.
- R3: For opCodes 1, 2, 3 and 5, destSel = 0 asserts wWrEn with the result in the same cycle, and W takes the result at the next clock edge. destSel = 1 instead asserts fileWrEn with fileWrAddr equal to fileAddr and fileWrData equal to the result, and W keeps its value.
- R4: OR with literal (opCode 4) produces W OR literal. It always writes W and never the file register, whatever destSel is.
- R5: OR with file register (opCode 5) produces W OR the file operand.
- R6: After an opCode 1, 4 or 5 operation, the zero flag is 1 if the 8-bit result was zero and 0 otherwise.
- R7: OpCodes 2 and 3 leave the zero flag unchanged.
- R8: zeroResult is 1 exactly when a valid opCode 2 or 3 produces a zero result in that cycle, and is 0 at all other times.
- R9: At most one of wWrEn and fileWrEn is asserted in any cycle. With opValid low, or with opCode 0, 6 or 7, neither is asserted and both W and the zero flag keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Operation fields are valid this cycle |
| opCode | input | 3 | Decoded operation: 0 none, 1 inc, 2 dec-skip, 3 inc-skip, 4 OR literal, 5 OR file |
| fileAddr | input | 7 | File-register operand address |
| destSel | input | 1 | 0 sends the result to W, 1 to the file register |
| literal | input | 8 | Immediate operand for OR with literal |
| fileRdData | input | 8 | Asynchronous read data of the file register at fileAddr |
| wWrEn | output | 1 | Working-register write this cycle |
| wWrData | output | 8 | Data written to the working register |
| fileWrEn | output | 1 | File-register write this cycle |
| fileWrAddr | output | 7 | File-register write address |
| fileWrData | output | 8 | Data written to the file register |
| zeroResult | output | 1 | Skip-type operation produced zero |
| wValue | output | 8 | Current working-register contents |
| zFlag | output | 1 | Current zero flag |

## Verification
The bench builds the block with its default parameters: an 8-bit data path and a 7-bit address. At that width every operand value is reachable. The bench sweeps all eight opCode values against all 256 file-operand values, with both settings of destSel. Before each operation it loads W with a value derived from the operand, which also sets the zero flag to a known state. This covers both wrap points, results that are zero and nonzero under every operation, and a zero flag that the skip operations must preserve both when it is set and when it is clear.

// File: rtl/fileAluPkg.sv
package fileAluPkg;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_INC   = 3'd1,
    OP_DECSZ = 3'd2,
    OP_INCSZ = 3'd3,
    OP_ORLIT = 3'd4,
    OP_ORREG = 3'd5
  } opCode_e;

  typedef enum logic [1:0] {
    ALU_INC = 2'd0,
    ALU_DEC = 2'd1,
    ALU_OR  = 2'd2
  } aluSel_e;

  typedef struct packed {
    logic    toW;
    logic    toFile;
    logic    zUpd;
    logic    skipOp;
    logic    useLit;
    aluSel_e aluSel;
  } strobe_t;

endpackage

// File: rtl/fileAluCtrl.sv
module fileAluCtrl
  import fileAluPkg::*;
(
  input  logic          opValid,
  input  logic [2:0]    opCode,
  input  logic          destSel,
  output strobe_t       strobe
);

  logic    active;
  logic    litOp;
  logic    zOp;
  logic    skipKind;
  aluSel_e sel;

  always_comb begin
    active   = opValid;
    litOp    = 1'b0;
    zOp      = 1'b0;
    skipKind = 1'b0;
    sel      = ALU_OR;
    case (opCode)
      OP_INC:   begin sel = ALU_INC; zOp = 1'b1; end
      OP_DECSZ: begin sel = ALU_DEC; skipKind = 1'b1; end
      OP_INCSZ: begin sel = ALU_INC; skipKind = 1'b1; end
      OP_ORLIT: begin sel = ALU_OR;  zOp = 1'b1; litOp = 1'b1; end
      OP_ORREG: begin sel = ALU_OR;  zOp = 1'b1; end
      default:  active = 1'b0;
    endcase
  end

  always_comb begin
    strobe.aluSel = sel;
    strobe.useLit = litOp;
    strobe.toW    = active && (litOp || !destSel);
    strobe.toFile = active && !litOp && destSel;
    strobe.zUpd   = active && zOp;
    strobe.skipOp = active && skipKind;
  end

endmodule

// File: rtl/fileAluPath.sv
module fileAluPath
  import fileAluPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [ADDR_W-1:0] fileAddr,
  input  logic [DATA_W-1:0] literal,
  input  logic [DATA_W-1:0] fileRdData,
  output logic              wWrEn,
  output logic [DATA_W-1:0] wWrData,
  output logic              fileWrEn,
  output logic [ADDR_W-1:0] fileWrAddr,
  output logic [DATA_W-1:0] fileWrData,
  output logic              zeroResult,
  output logic [DATA_W-1:0] wValue,
  output logic              zFlag
);

  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic [DATA_W-1:0] wReg;
  logic              zReg;
  logic [DATA_W-1:0] orOperand;
  logic [DATA_W-1:0] result;
  logic              resultZero;

  assign orOperand = strobe.useLit ? literal : fileRdData;

  always_comb begin
    case (strobe.aluSel)
      ALU_INC: result = fileRdData + ONE;
      ALU_DEC: result = fileRdData - ONE;
      default: result = wReg | orOperand;
    endcase
  end

  assign resultZero = (result == '0);

  assign wWrEn      = strobe.toW;
  assign wWrData    = result;
  assign fileWrEn   = strobe.toFile;
  assign fileWrAddr = fileAddr;
  assign fileWrData = result;
  assign zeroResult = strobe.skipOp && resultZero;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wReg <= '0;
      zReg <= 1'b0;
    end else begin
      if (strobe.toW) wReg <= result;
      if (strobe.zUpd) zReg <= resultZero;
    end
  end

  assign wValue = wReg;
  assign zFlag  = zReg;

endmodule

// File: rtl/fileAluCore.sv
module fileAluCore
  import fileAluPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [2:0]        opCode,
  input  logic [ADDR_W-1:0] fileAddr,
  input  logic              destSel,
  input  logic [DATA_W-1:0] literal,
  input  logic [DATA_W-1:0] fileRdData,
  output logic              wWrEn,
  output logic [DATA_W-1:0] wWrData,
  output logic              fileWrEn,
  output logic [ADDR_W-1:0] fileWrAddr,
  output logic [DATA_W-1:0] fileWrData,
  output logic              zeroResult,
  output logic [DATA_W-1:0] wValue,
  output logic              zFlag
);

  strobe_t strobe;

  fileAluCtrl uCtrl (
    .opValid (opValid),
    .opCode  (opCode),
    .destSel (destSel),
    .strobe  (strobe)
  );

  fileAluPath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .fileAddr   (fileAddr),
    .literal    (literal),
    .fileRdData (fileRdData),
    .wWrEn      (wWrEn),
    .wWrData    (wWrData),
    .fileWrEn   (fileWrEn),
    .fileWrAddr (fileWrAddr),
    .fileWrData (fileWrData),
    .zeroResult (zeroResult),
    .wValue     (wValue),
    .zFlag      (zFlag)
  );

endmodule

// File: rtl/fileAluChecker.sv
module fileAluChecker #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic              opValid,
  input logic [2:0]        opCode,
  input logic [ADDR_W-1:0] fileAddr,
  input logic              destSel,
  input logic [DATA_W-1:0] literal,
  input logic [DATA_W-1:0] fileRdData,
  input logic              wWrEn,
  input logic              fileWrEn,
  input logic              zeroResult,
  input logic [DATA_W-1:0] wValue,
  input logic              zFlag
);

  logic skipIn;
  assign skipIn = opValid && (opCode == 3'd2 || opCode == 3'd3);

  a_r9_single_write: assert property (@(posedge clk) disable iff (!rstN)
    !(wWrEn && fileWrEn));

  a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> $stable(wValue) && $stable(zFlag));

  a_r7_skip_keeps_z: assert property (@(posedge clk) disable iff (!rstN)
    skipIn |=> $stable(zFlag));

  a_r8_zero_only_skip: assert property (@(posedge clk) disable iff (!rstN)
    zeroResult |-> skipIn);

  a_r4_lit_to_w: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == 3'd4) |=> wValue == ($past(wValue) | $past(literal)));

  a_r3_file_dest: assert property (@(posedge clk) disable iff (!rstN)
    fileWrEn |-> (opValid && destSel));

  a_r6_z_after_inc_w: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == 3'd1 && !destSel) |=> zFlag == (wValue == '0));

endmodule

bind fileAluCore fileAluChecker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .opValid    (opValid),
  .opCode     (opCode),
  .fileAddr   (fileAddr),
  .destSel    (destSel),
  .literal    (literal),
  .fileRdData (fileRdData),
  .wWrEn      (wWrEn),
  .fileWrEn   (fileWrEn),
  .zeroResult (zeroResult),
  .wValue     (wValue),
  .zFlag      (zFlag)
);

// File: tb/sim_fileAluCore.sv
`timescale 1ns/1ps
module sim_fileAluCore;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       opValid = 1'b0;
  logic [2:0] opCode = 3'd0;
  logic [6:0] fileAddr = 7'd0;
  logic       destSel = 1'b0;
  logic [7:0] literal = 8'd0;
  logic [7:0] fileRdData;
  logic       wWrEn, fileWrEn, zeroResult, zFlag;
  logic [7:0] wWrData, fileWrData, wValue;
  logic [6:0] fileWrAddr;

  logic [7:0] mem [128];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  assign fileRdData = mem[fileAddr];
  always @(posedge clk) if (fileWrEn) mem[fileWrAddr] <= fileWrData;

  fileAluCore u0 (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .fileAddr(fileAddr), .destSel(destSel), .literal(literal),
    .fileRdData(fileRdData), .wWrEn(wWrEn), .wWrData(wWrData),
    .fileWrEn(fileWrEn), .fileWrAddr(fileWrAddr), .fileWrData(fileWrData),
    .zeroResult(zeroResult), .wValue(wValue), .zFlag(zFlag)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic v, input logic [2:0] op, input logic [6:0] a,
                       input logic d, input logic [7:0] lit);
    @(negedge clk);
    opValid = v; opCode = op; fileAddr = a; destSel = d; literal = lit;
  endtask

  task automatic loadW(input logic [7:0] w);
    mem[127] = w - 8'd1;
    issue(1'b1, 3'd1, 7'd127, 1'b0, 8'd0);
    @(posedge clk);
  endtask

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = 8'd0;
    repeat (3) @(posedge clk);
    #2;
    chk("R1 w reset", wValue, 0);
    chk("R1 z reset", zFlag, 0);
    chk("R1 no write", {wWrEn, fileWrEn}, 0);
    @(negedge clk);
    rstN = 1'b1;
    #2;
    chk("R1 w after release", wValue, 0);
    chk("R1 z after release", zFlag, 0);
    chk("R1 no write after release", {wWrEn, fileWrEn}, 0);

    for (int op = 0; op < 8; op++) begin
      for (int x = 0; x < 256; x++) begin
        for (int d = 0; d < 2; d++) begin
          logic [7:0] w, lit, res, xv;
          logic [6:0] a;
          logic act, expW, expF, zUpd, expZr, zPrev, v;
          xv  = 8'(x);
          w   = xv ^ 8'h5A ^ 8'(op * 37);
          lit = {xv[3:0], xv[7:4]} ^ 8'h0F;
          a   = (xv[6:0] == 7'd127) ? 7'd3 : xv[6:0];
          v   = !(op == 5 && x[2:0] == 3'd6 && d == 1);
          loadW(w);
          zPrev = (w == 8'd0);
          mem[a] = xv;
          issue(v, 3'(op), a, 1'(d), lit);
          case (op)
            1, 3:    res = xv + 8'd1;
            2:       res = xv - 8'd1;
            4:       res = w | lit;
            5:       res = w | xv;
            default: res = 8'd0;
          endcase
          act   = v && (op >= 1 && op <= 5);
          expW  = act && (op == 4 || d == 0);
          expF  = act && op != 4 && d == 1;
          zUpd  = act && (op == 1 || op == 4 || op == 5);
          expZr = act && (op == 2 || op == 3) && res == 8'd0;
          #2;
          chk("R9 wWrEn", wWrEn, expW);
          chk(op == 4 ? "R4 fileWrEn" : "R3 fileWrEn", fileWrEn, expF);
          if (expW) chk(op == 4 ? "R4 wWrData" : (op == 5 ? "R5 wWrData" : "R2 wWrData"), wWrData, res);
          if (expF) begin
            chk(op == 5 ? "R5 fileWrData" : "R2 fileWrData", fileWrData, res);
            chk("R3 fileWrAddr", fileWrAddr, a);
          end
          chk("R8 zeroResult", zeroResult, expZr);
          @(posedge clk);
          #1;
          chk("R3 wValue", wValue, expW ? res : w);
          if (zUpd) chk("R6 zFlag", zFlag, res == 8'd0);
          else if (op == 2 || op == 3) chk("R7 zFlag kept", zFlag, zPrev);
          else chk("R9 zFlag kept", zFlag, zPrev);
          chk("R3 file contents", mem[a], expF ? res : xv);
        end
      end
    end

    opValid = 1'b0;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule